// File: doc/BRIEF.md
# Directory Coherence Controller

This block is the central point of coherence for a small set of cached memory lines shared by up to a few processors. It holds one directory entry per tracked line: a bit vector that shows which processors keep a copy, and an optional exclusive owner. Cache controllers send it read-miss, exclusive-access and eviction requests over a single valid/ready channel. The controller sends invalidate and write-back commands to the caches and counts their acknowledgements. It then answers with a grant that names the processor, the line and whether access is shared or exclusive.

Only one transaction is in progress at a time. A request that needs other caches to act first keeps the request channel closed until it is granted. Caches report evictions through the same channel, so the directory always reflects every local change of a line's global status. The data path and memory timing belong to other blocks.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `grant_valid` is 0, `cmd_valid` is all zero, and every line has no sharers and no owner.
- R2: A read request (`req_op` = 0) on a line with no owner, or on a line the requester owns, is granted in the cycle after acceptance with no command issued. `grant_excl` is 1 only when the requester is the owner. The requester is recorded as a sharer.
- R3: An exclusive request (`req_op` = 1) on an unowned line where no other processor is a sharer is granted exclusive in the cycle after acceptance, with no command issued.
- R4: An exclusive request on an unowned line with other sharers issues, in the cycle after acceptance, one invalidate command (`cmd_kind` = 0) whose `cmd_valid` bits equal exactly the other sharers. `cmd_line` names the line.
- R5: An outstanding command set completes only after an acknowledgement from every targeted processor. Several acknowledgements in one cycle all count. Acknowledgements from processors that were not targeted are ignored. The grant appears in the cycle after the last needed acknowledgement.
- R6: A read request on a line owned by another processor issues a write-back command (`cmd_kind` = 1) to that owner only. After its acknowledgement, a shared grant follows, and both the former owner and the requester are sharers while the line has no owner.
- R7: An exclusive request on a line owned by another processor issues a write-back to the owner. After that acknowledgement it issues an invalidate to the owner, and after that acknowledgement it grants exclusive.
- R8: After an exclusive grant, the requester is the only sharer and is the owner of the line.
- R9: From the acceptance of a request that issues a command until its grant, `req_ready` is 0. `req_ready` is 1 whenever a grant is shown.
- R10: An eviction request (`req_op` = 2 or 3) removes the requester from the sharers and drops its ownership. It produces no grant and no command, and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_proc | input | PW | Requesting processor index |
| req_line | input | LW | Line index |
| req_op | input | 2 | 0 read, 1 exclusive, 2/3 eviction |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_proc | output | PW | Processor being granted |
| grant_line | output | LW | Line being granted |
| grant_excl | output | 1 | 1 exclusive, 0 shared |
| cmd_valid | output | N_PROC | One-cycle command pulse per target processor |
| cmd_kind | output | 1 | 0 invalidate, 1 write-back |
| cmd_line | output | LW | Line the command refers to |
| ack_valid | input | N_PROC | Per-processor command acknowledgement pulse |

## Verification
Two functions can meet in one cycle: the arrival of several invalidation acknowledgements, and the decision to grant. The bench can also drive acknowledgements from processors that were never commanded in that same cycle. Random per-sharer delays, an all-at-once mode and injected stray acknowledgements provoke this. It is judged by requiring that no grant appears while any targeted processor is still silent, and that the grant appears exactly one cycle after the last needed acknowledgement. A further case joins a write-back acknowledgement to the invalidate that must follow it at once, on an exclusive request against a foreign owner.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_EXCL  = 2'd1,
      OP_EVICT = 2'd2
   } coh_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WB   = 2'd1,
      ST_INV  = 2'd2
   } coh_st_e;

   localparam logic CMD_INV = 1'b0;
   localparam logic CMD_WB  = 1'b1;

endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store #(
   parameter int N_PROC  = 4,
   parameter int N_LINES = 8,
   localparam int PW = (N_PROC > 1) ? $clog2(N_PROC) : 1,
   localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LW-1:0]     rd_line,
   output logic [N_PROC-1:0] rd_pres,
   output logic              rd_own_v,
   output logic [PW-1:0]     rd_own_id,
   input  logic              wr_en,
   input  logic [LW-1:0]     wr_line,
   input  logic [N_PROC-1:0] wr_pres,
   input  logic              wr_own_v,
   input  logic [PW-1:0]     wr_own_id
);

   logic [N_LINES-1:0][N_PROC-1:0] pres_all;
   logic [N_LINES-1:0]             own_v_all;
   logic [N_LINES-1:0][PW-1:0]     own_id_all;

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      logic [N_PROC-1:0] pres_q;
      logic              own_v_q;
      logic [PW-1:0]     own_id_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pres_q   <= '0;
            own_v_q  <= 1'b0;
            own_id_q <= '0;
         end else if (wr_en && (wr_line == LW'(g))) begin
            pres_q   <= wr_pres;
            own_v_q  <= wr_own_v;
            own_id_q <= wr_own_id;
         end
      end

      assign pres_all[g]   = pres_q;
      assign own_v_all[g]  = own_v_q;
      assign own_id_all[g] = own_id_q;
   end

   always_comb begin
      rd_pres   = '0;
      rd_own_v  = 1'b0;
      rd_own_id = '0;
      for (int i = 0; i < N_LINES; i++) begin
         if (rd_line == LW'(i)) begin
            rd_pres   = pres_all[i];
            rd_own_v  = own_v_all[i];
            rd_own_id = own_id_all[i];
         end
      end
   end

endmodule

// File: rtl/coh_ack_tracker.sv
module coh_ack_tracker #(
   parameter int N_PROC = 4,
   localparam int CW = $clog2(N_PROC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [N_PROC-1:0] load_mask,
   input  logic [N_PROC-1:0] ack,
   output logic [N_PROC-1:0] pend,
   output logic [CW-1:0]     cnt,
   output logic              last
);

   logic [N_PROC-1:0] pend_q;
   logic [CW-1:0]     cnt_q;
   logic [N_PROC-1:0] hits;
   logic [CW-1:0]     hit_n;
   logic [CW-1:0]     load_n;

   assign hits = ack & pend_q;

   always_comb begin
      hit_n  = '0;
      load_n = '0;
      for (int i = 0; i < N_PROC; i++) begin
         if (hits[i])      hit_n  = hit_n + CW'(1);
         if (load_mask[i]) load_n = load_n + CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         pend_q <= load_mask;
         cnt_q  <= load_n;
      end else begin
         pend_q <= pend_q & ~ack;
         cnt_q  <= cnt_q - hit_n;
      end
   end

   assign pend = pend_q;
   assign cnt  = cnt_q;
   assign last = (cnt_q != '0) && (hit_n == cnt_q);

endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
   import coh_dir_pkg::*;
#(
   parameter int N_PROC  = 4,
   parameter int N_LINES = 8,
   localparam int PW = (N_PROC > 1) ? $clog2(N_PROC) : 1,
   localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1,
   localparam int CW = $clog2(N_PROC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [PW-1:0]     req_proc,
   input  logic [LW-1:0]     req_line,
   input  logic [1:0]        req_op,
   output logic              grant_valid,
   output logic [PW-1:0]     grant_proc,
   output logic [LW-1:0]     grant_line,
   output logic              grant_excl,
   output logic [N_PROC-1:0] cmd_valid,
   output logic              cmd_kind,
   output logic [LW-1:0]     cmd_line,
   input  logic [N_PROC-1:0] ack_valid
);

   if (N_PROC < 2 || N_PROC > 16) begin : g_bad_nproc
      $error("coh_dir_ctrl: N_PROC must be within 2..16");
   end
   if (N_LINES < 1 || N_LINES > 256) begin : g_bad_nlines
      $error("coh_dir_ctrl: N_LINES must be within 1..256");
   end

   coh_st_e st_q, st_d;
   logic [PW-1:0] t_proc_q, t_proc_d;
   logic [LW-1:0] t_line_q, t_line_d;
   logic          t_excl_q, t_excl_d;
   logic [PW-1:0] t_own_q,  t_own_d;

   logic [LW-1:0]     rd_line;
   logic [N_PROC-1:0] rd_pres;
   logic              rd_own_v;
   logic [PW-1:0]     rd_own_id;
   logic              wr_en;
   logic [N_PROC-1:0] wr_pres;
   logic              wr_own_v;
   logic [PW-1:0]     wr_own_id;

   logic              trk_load;
   logic [N_PROC-1:0] trk_mask;
   logic [N_PROC-1:0] trk_pend;
   logic [CW-1:0]     trk_cnt;
   logic              trk_last;

   logic              gnt_v_d, gnt_x_d;
   logic [PW-1:0]     gnt_p_d;
   logic [LW-1:0]     gnt_l_d;
   logic [N_PROC-1:0] cmd_v_d;
   logic              cmd_k_d;
   logic [LW-1:0]     cmd_l_d;

   logic              gnt_v_q, gnt_x_q;
   logic [PW-1:0]     gnt_p_q;
   logic [LW-1:0]     gnt_l_q;
   logic [N_PROC-1:0] cmd_v_q;
   logic              cmd_k_q;
   logic [LW-1:0]     cmd_l_q;

   logic              accept;
   logic [N_PROC-1:0] req_bit, t_bit, t_own_bit, rd_own_bit, others;
   logic              foreign_owner, self_owner;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign rd_line   = (st_q == ST_IDLE) ? req_line : t_line_q;

   assign req_bit    = N_PROC'(1) << req_proc;
   assign t_bit      = N_PROC'(1) << t_proc_q;
   assign t_own_bit  = N_PROC'(1) << t_own_q;
   assign rd_own_bit = N_PROC'(1) << rd_own_id;
   assign others     = rd_pres & ~req_bit;
   assign foreign_owner = rd_own_v && (rd_own_id != req_proc);
   assign self_owner    = rd_own_v && (rd_own_id == req_proc);

   coh_dir_store #(
      .N_PROC  (N_PROC),
      .N_LINES (N_LINES)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_line   (rd_line),
      .rd_pres   (rd_pres),
      .rd_own_v  (rd_own_v),
      .rd_own_id (rd_own_id),
      .wr_en     (wr_en),
      .wr_line   (rd_line),
      .wr_pres   (wr_pres),
      .wr_own_v  (wr_own_v),
      .wr_own_id (wr_own_id)
   );

   coh_ack_tracker #(
      .N_PROC (N_PROC)
   ) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (trk_load),
      .load_mask (trk_mask),
      .ack       (ack_valid),
      .pend      (trk_pend),
      .cnt       (trk_cnt),
      .last      (trk_last)
   );

   always_comb begin
      st_d      = st_q;
      t_proc_d  = t_proc_q;
      t_line_d  = t_line_q;
      t_excl_d  = t_excl_q;
      t_own_d   = t_own_q;
      wr_en     = 1'b0;
      wr_pres   = rd_pres;
      wr_own_v  = rd_own_v;
      wr_own_id = rd_own_id;
      trk_load  = 1'b0;
      trk_mask  = '0;
      gnt_v_d   = 1'b0;
      gnt_x_d   = 1'b0;
      gnt_p_d   = gnt_p_q;
      gnt_l_d   = gnt_l_q;
      cmd_v_d   = '0;
      cmd_k_d   = cmd_k_q;
      cmd_l_d   = cmd_l_q;

      unique case (st_q)
         ST_IDLE: begin
            if (accept) begin
               t_proc_d = req_proc;
               t_line_d = req_line;
               t_own_d  = rd_own_id;
               if (req_op == OP_READ || req_op == OP_EXCL) begin
                  t_excl_d = (req_op == OP_EXCL);
                  if (foreign_owner) begin
                     cmd_v_d  = rd_own_bit;
                     cmd_k_d  = CMD_WB;
                     cmd_l_d  = req_line;
                     trk_load = 1'b1;
                     trk_mask = rd_own_bit;
                     st_d     = ST_WB;
                  end else if (req_op == OP_READ) begin
                     wr_en   = 1'b1;
                     wr_pres = rd_pres | req_bit;
                     gnt_v_d = 1'b1;
                     gnt_x_d = self_owner;
                     gnt_p_d = req_proc;
                     gnt_l_d = req_line;
                  end else if (others == '0) begin
                     wr_en     = 1'b1;
                     wr_pres   = req_bit;
                     wr_own_v  = 1'b1;
                     wr_own_id = req_proc;
                     gnt_v_d   = 1'b1;
                     gnt_x_d   = 1'b1;
                     gnt_p_d   = req_proc;
                     gnt_l_d   = req_line;
                  end else begin
                     cmd_v_d  = others;
                     cmd_k_d  = CMD_INV;
                     cmd_l_d  = req_line;
                     trk_load = 1'b1;
                     trk_mask = others;
                     st_d     = ST_INV;
                  end
               end else begin
                  wr_en    = 1'b1;
                  wr_pres  = rd_pres & ~req_bit;
                  wr_own_v = rd_own_v && !self_owner;
               end
            end
         end

         ST_WB: begin
            if (trk_last) begin
               if (t_excl_q) begin
                  cmd_v_d  = t_own_bit;
                  cmd_k_d  = CMD_INV;
                  cmd_l_d  = t_line_q;
                  trk_load = 1'b1;
                  trk_mask = t_own_bit;
                  st_d     = ST_INV;
               end else begin
                  wr_en    = 1'b1;
                  wr_pres  = rd_pres | t_bit | t_own_bit;
                  wr_own_v = 1'b0;
                  gnt_v_d  = 1'b1;
                  gnt_x_d  = 1'b0;
                  gnt_p_d  = t_proc_q;
                  gnt_l_d  = t_line_q;
                  st_d     = ST_IDLE;
               end
            end
         end

         ST_INV: begin
            if (trk_last) begin
               wr_en     = 1'b1;
               wr_pres   = t_bit;
               wr_own_v  = 1'b1;
               wr_own_id = t_proc_q;
               gnt_v_d   = 1'b1;
               gnt_x_d   = 1'b1;
               gnt_p_d   = t_proc_q;
               gnt_l_d   = t_line_q;
               st_d      = ST_IDLE;
            end
         end

         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         t_proc_q <= '0;
         t_line_q <= '0;
         t_excl_q <= 1'b0;
         t_own_q  <= '0;
         gnt_v_q  <= 1'b0;
         gnt_x_q  <= 1'b0;
         gnt_p_q  <= '0;
         gnt_l_q  <= '0;
         cmd_v_q  <= '0;
         cmd_k_q  <= 1'b0;
         cmd_l_q  <= '0;
      end else begin
         st_q     <= st_d;
         t_proc_q <= t_proc_d;
         t_line_q <= t_line_d;
         t_excl_q <= t_excl_d;
         t_own_q  <= t_own_d;
         gnt_v_q  <= gnt_v_d;
         gnt_x_q  <= gnt_x_d;
         gnt_p_q  <= gnt_p_d;
         gnt_l_q  <= gnt_l_d;
         cmd_v_q  <= cmd_v_d;
         cmd_k_q  <= cmd_k_d;
         cmd_l_q  <= cmd_l_d;
      end
   end

   assign grant_valid = gnt_v_q;
   assign grant_excl  = gnt_x_q;
   assign grant_proc  = gnt_p_q;
   assign grant_line  = gnt_l_q;
   assign cmd_valid   = cmd_v_q;
   assign cmd_kind    = cmd_k_q;
   assign cmd_line    = cmd_l_q;

endmodule

// File: rtl/coh_dir_chk.sv
module coh_dir_chk #(
   parameter int N_PROC = 4,
   localparam int CW = $clog2(N_PROC + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              grant_valid,
   input logic [N_PROC-1:0] cmd_valid,
   input logic              cmd_kind,
   input logic [N_PROC-1:0] trk_pend,
   input logic [CW-1:0]     trk_cnt
);

   p_grant_when_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> req_ready);

   p_reopen_grants_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_ready) |-> grant_valid);

   p_closed_has_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> (trk_cnt != '0));

   p_cmd_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid != '0) |-> !req_ready);

   p_grant_no_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (cmd_valid == '0));

   p_count_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trk_cnt == CW'($countones(trk_pend)));

   p_wb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_valid != '0) && cmd_kind) |-> $onehot(cmd_valid));

endmodule

bind coh_dir_ctrl coh_dir_chk #(.N_PROC(N_PROC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .grant_valid (grant_valid),
   .cmd_valid   (cmd_valid),
   .cmd_kind    (cmd_kind),
   .trk_pend    (trk_pend),
   .trk_cnt     (trk_cnt)
);

// File: tb/tb_coh_dir_ctrl.sv
`timescale 1ns/1ps
module tb_coh_dir_ctrl;
   localparam int NP = 4;
   localparam int NL = 8;
   localparam int PW = 2;
   localparam int LW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [PW-1:0] req_proc = '0;
   logic [LW-1:0] req_line = '0;
   logic [1:0]    req_op = '0;
   logic          grant_valid;
   logic [PW-1:0] grant_proc;
   logic [LW-1:0] grant_line;
   logic          grant_excl;
   logic [NP-1:0] cmd_valid;
   logic          cmd_kind;
   logic [LW-1:0] cmd_line;
   logic [NP-1:0] ack_valid = '0;

   always #2.5 clk = ~clk;

   coh_dir_ctrl #(.N_PROC(NP), .N_LINES(NL)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_proc(req_proc), .req_line(req_line), .req_op(req_op),
      .grant_valid(grant_valid), .grant_proc(grant_proc), .grant_line(grant_line),
      .grant_excl(grant_excl), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
      .cmd_line(cmd_line), .ack_valid(ack_valid)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [NP-1:0] m_pres [NL];
   logic          m_ov   [NL];
   int            m_oid  [NL];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int grant_word(input bit x, input int p, input int l);
      return (1 << 8) | (int'(x) << 6) | (p << 3) | l;
   endfunction

   function automatic int cmd_word(input bit k, input logic [NP-1:0] m, input int l);
      return (int'(k) << 8) | (int'(m) << 3) | l;
   endfunction

   task automatic expect_grant(input string tag, input bit x, input int p, input int l);
      chk(grant_valid && cmd_valid == '0 &&
          grant_word(grant_excl, grant_proc, grant_line) == grant_word(x, p, l),
          tag, grant_valid ? grant_word(grant_excl, grant_proc, grant_line) : 0,
          grant_word(x, p, l));
   endtask

   task automatic expect_cmd(input string tag, input bit k, input logic [NP-1:0] m, input int l);
      chk(!grant_valid && cmd_word(cmd_kind, cmd_valid, cmd_line) == cmd_word(k, m, l),
          tag, cmd_word(cmd_kind, cmd_valid, cmd_line), cmd_word(k, m, l));
   endtask

   // Acknowledge the targets in mask; mode 0 random delays, 1 all at once.
   task automatic ack_phase(input logic [NP-1:0] mask, input int mode, input bit stray);
      int d [NP];
      int maxd = 0;
      int common = $urandom_range(0, 3);
      for (int i = 0; i < NP; i++) begin
         d[i] = (mode == 1) ? common : $urandom_range(0, 3);
         if (mask[i] && d[i] > maxd) maxd = d[i];
      end
      for (int t = 0; t <= maxd; t++) begin
         if (t > 0) begin
            chk(!grant_valid, "R5 no early grant", grant_valid, 0);
            chk(!req_ready, "R9 ready held low", req_ready, 0);
         end
         ack_valid = '0;
         for (int i = 0; i < NP; i++)
            if (mask[i] && d[i] == t) ack_valid[i] = 1'b1;
         if (stray) begin
            int j = $urandom_range(0, NP - 1);
            if (!mask[j]) ack_valid[j] = 1'b1;
         end
         @(negedge clk);
      end
      ack_valid = '0;
   endtask

   task automatic do_req(input int p, input int l, input int op, input int mode, input bit stray);
      logic [NP-1:0] pb = NP'(1) << p;
      logic [NP-1:0] ob = NP'(1) << m_oid[l];
      logic [NP-1:0] oth = m_pres[l] & ~pb;
      bit foreign = m_ov[l] && m_oid[l] != p;
      chk(req_ready, "R9 ready before request", req_ready, 1);
      req_valid = 1'b1;
      req_proc  = PW'(p);
      req_line  = LW'(l);
      req_op    = 2'(op);
      @(negedge clk);
      req_valid = 1'b0;
      if (op >= 2) begin
         chk(!grant_valid && cmd_valid == '0 && req_ready, "R10 eviction silent",
             {grant_valid, cmd_valid, req_ready}, 1);
         m_pres[l] &= ~pb;
         if (m_ov[l] && m_oid[l] == p) m_ov[l] = 1'b0;
      end else if (op == 0) begin
         if (foreign) begin
            expect_cmd("R6 write-back to owner", 1'b1, ob, l);
            chk(!req_ready, "R9 ready low after command", req_ready, 0);
            ack_phase(ob, mode, stray);
            expect_grant("R6 shared grant after write-back", 1'b0, p, l);
            m_pres[l] |= pb | ob;
            m_ov[l] = 1'b0;
         end else begin
            expect_grant("R2 immediate read grant", m_ov[l], p, l);
            m_pres[l] |= pb;
         end
      end else begin
         if (foreign) begin
            expect_cmd("R7 write-back before invalidate", 1'b1, ob, l);
            ack_phase(ob, mode, stray);
            expect_cmd("R7 invalidate owner after write-back", 1'b0, ob, l);
            ack_phase(ob, mode, stray);
            expect_grant("R7 exclusive grant", 1'b1, p, l);
         end else if (oth == '0) begin
            expect_grant("R3 immediate exclusive grant", 1'b1, p, l);
         end else begin
            expect_cmd("R4 invalidate other sharers", 1'b0, oth, l);
            ack_phase(oth, mode, stray);
            expect_grant("R5 grant after last ack", 1'b1, p, l);
         end
         m_pres[l] = pb;   // R8
         m_ov[l]   = 1'b1;
         m_oid[l]  = p;
      end
      chk(req_ready, "R9 ready after completion", req_ready, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      for (int i = 0; i < NL; i++) begin
         m_pres[i] = '0;
         m_ov[i]   = 1'b0;
         m_oid[i]  = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !grant_valid && cmd_valid == '0, "R1 reset state",
          {req_ready, grant_valid, cmd_valid}, 6'b100000);

      do_req(0, 1, 0, 0, 0);   // R2 read, empty line
      do_req(0, 1, 1, 0, 0);   // R3 sole sharer upgrade
      do_req(1, 1, 0, 0, 0);   // R6 read on owned line
      do_req(2, 1, 0, 0, 0);   // R2 read, shared line
      do_req(3, 1, 1, 1, 0);   // R4 R5 simultaneous acks
      do_req(3, 1, 0, 0, 0);   // R2 owner reads its own line
      do_req(2, 1, 1, 0, 1);   // R7 foreign owner, stray acks
      do_req(2, 1, 3, 0, 0);   // R10 owner evicts
      do_req(0, 1, 0, 0, 0);   // R10 no write-back after eviction
      do_req(1, 2, 1, 0, 0);   // R3 empty line
      do_req(0, 2, 0, 1, 0);   // R8 owner is the only copy
      for (int n = 0; n < 400; n++) begin
         int r  = $urandom_range(0, 99);
         int op = (r < 45) ? 0 : (r < 85) ? 1 : 2 + (r & 1);
         do_req($urandom_range(0, NP - 1), $urandom_range(0, 3), op,
                $urandom_range(0, 1), bit'($urandom_range(0, 1)));
      end
      // R10 ignored eviction by a non-sharer leaves the line untouched
      do_req(0, 5, 1, 0, 0);
      do_req(3, 5, 2, 0, 0);
      do_req(1, 5, 0, 0, 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule